// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only target on a two-wire serial bus (I2C/SMBus style). It loads a small bank of configuration registers that steer a clock-generator device. It samples the bus clock and data lines into the system clock domain and detects start and stop conditions. It checks the first byte of each frame against a fixed 7-bit device address with a write direction bit. For a matching frame it pulls the data line low in the ninth clock of every byte. The data line output is an open-drain enable.

A frame is a block write: the address byte comes first, then a command byte and a count byte, both of which are acknowledged and then dropped. Every byte after those is a data byte. Data bytes fill the registers in ascending order, starting at register 0, and each byte is committed at the moment its acknowledge begins. Bytes past the last register are acknowledged and thrown away. After reset the bank holds default values, so software only needs to write it when those defaults do not suit.

The register bank is decoded as follows. Register 0 carries the frequency select in bits 2:0, the spread-spectrum enable in bit 3 and the output tristate control in bit 4. Registers 1 and up carry one disable bit per clock output. When a disable bit is set, that output is driven low rather than floated.

Top module: `cfg_twowire_slave`

## Requirements
- R1: A start condition is the data line falling while the clock line is high, and a stop condition is the data line rising while the clock line is high. Both are recognised in any state.
- R2: If the first byte after a start is 0xD2 (address 1101001, MSB first, followed by write bit 0), the slave holds the data line low for the whole ninth clock of that byte.
- R3: If the first byte is any other value, including the read form 0xD3, the slave gives no acknowledge and ignores the bus until the next start. No register changes.
- R4: Data bits are taken while the clock is high, MSB first. The open-drain enable changes only while the clock is low, except for the release forced by a start or stop. The slave never pulls the line during the eight data bits of a byte.
- R5: In a matched frame, the second byte (command) and the third byte (count) are acknowledged, and their values have no effect on any register or on where the data bytes land.
- R6: Data byte k (k = 0, 1, ...) of a matched frame is written to register k when its acknowledge starts. Registers that the frame does not reach keep their values.
- R7: After reset, register 0 is 0x0B (frequency select 3, spread enable 1, tristate 0) and registers 1 to 2 are 0x00 (all outputs enabled). Outputs: freq_sel_o = reg0[2:0], spread_en_o = reg0[3], tristate_o = reg0[4], out_dis_o = {reg2, reg1}, where bit i set disables output i.
- R8: After a stop, the slave releases the data line and acknowledges nothing, and writes nothing, until the next start.
- R9: Data bytes beyond the last register are acknowledged and discarded.
- R10: A repeated start in the middle of a frame returns the slave to address reception. The byte after it is treated as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| freq_sel_o | output | 3 | Frequency select (reg0[2:0]) |
| spread_en_o | output | 1 | Spread-spectrum enable (reg0[3]) |
| tristate_o | output | 1 | Place clock outputs in high impedance (reg0[4]) |
| out_dis_o | output | 16 | Per-output disable bits, held-low when set ({reg2, reg1}) |

## Verification
The bench uses the default parameters: three registers, device address 0x69 and the default register values. Three registers are few enough that a five-data-byte frame overruns the bank, which covers the discard path past the last register. A one-byte frame covers the partial-write case, and the default values are checked in the reset test. With the bus half-period set to eight system clocks, the two-flop input delay stays well inside each bus phase. This lets the bench sample the acknowledge in the middle of the ninth high phase.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RECV = 2'd1,
    FS_ACK  = 2'd2,
    FS_SKIP = 2'd3
  } frame_st_e;

  // Index of the first data byte in a frame (address, command, count precede it)
  localparam int FIRST_DATA_IDX = 3;
  localparam int FSEL_W         = 3;
  localparam int BYTE_W         = 8;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int          W        = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 3,
  parameter int         REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  output logic              start_o,
  output logic              stop_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int          IDX_MAX   = FIRST_DATA_IDX + NUM_REGS;
  localparam int          IDX_W     = $clog2(IDX_MAX + 1);
  localparam logic [7:0]  ADDR_BYTE = {DEV_ADDR, 1'b0};

  frame_st_e          st_q, st_n;
  logic [3:0]         bit_q, bit_n;
  logic [7:0]         sh_q, sh_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               oe_q, oe_n;
  logic               wr_q, wr_n;
  logic               scl_d, sda_d;
  logic               scl_rise, scl_fall;
  logic               in_bank;

  // Previous synchronized levels for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_o  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_o   = scl_q & scl_d & ~sda_d & sda_q;
  assign in_bank  = (idx_q >= IDX_W'(FIRST_DATA_IDX)) && (idx_q < IDX_W'(IDX_MAX));

  always_comb begin
    st_n  = st_q;
    bit_n = bit_q;
    sh_n  = sh_q;
    idx_n = idx_q;
    oe_n  = oe_q;
    wr_n  = 1'b0;
    if (start_o) begin
      st_n  = FS_RECV;
      bit_n = 4'd0;
      idx_n = '0;
      oe_n  = 1'b0;
    end else if (stop_o) begin
      st_n = FS_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        FS_RECV: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_q};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (idx_q == '0 && sh_q != ADDR_BYTE) begin
              st_n = FS_SKIP;
            end else begin
              st_n = FS_ACK;
              oe_n = 1'b1;
              wr_n = in_bank;
            end
          end
        end
        FS_ACK: begin
          if (scl_fall) begin
            st_n  = FS_RECV;
            oe_n  = 1'b0;
            bit_n = 4'd0;
            if (idx_q != IDX_W'(IDX_MAX)) idx_n = idx_q + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      bit_q <= 4'd0;
      sh_q  <= 8'd0;
      idx_q <= '0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      bit_q <= bit_n;
      sh_q  <= sh_n;
      idx_q <= idx_n;
      oe_q  <= oe_n;
      wr_q  <= wr_n;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = sh_q;
  assign wr_idx_o  = REG_W'(idx_q - IDX_W'(FIRST_DATA_IDX));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgslv_pkg::*;
#(
  parameter int                        NUM_REGS = 3,
  parameter int                        REG_W    = $clog2(NUM_REGS),
  parameter logic [8*NUM_REGS-1:0]     DEFAULTS = {8'h00, 8'h00, 8'h0B}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [REG_W-1:0]          wr_idx_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  output logic [BYTE_W*NUM_REGS-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] r_q;
    logic              hit;

    assign hit = wr_en_i && (wr_idx_i == REG_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= DEFAULTS[BYTE_W*i +: BYTE_W];
      else if (hit) r_q <= wr_data_i;
    end

    assign regs_o[BYTE_W*i +: BYTE_W] = r_q;
  end
endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
  import cfgslv_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR = 7'h69,
  parameter int                    NUM_REGS = 3,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS = {8'h00, 8'h00, 8'h0B}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe_o,
  output logic [FSEL_W-1:0]            freq_sel_o,
  output logic                         spread_en_o,
  output logic                         tristate_o,
  output logic [8*(NUM_REGS-1)-1:0]    out_dis_o
);
  localparam int REG_W = $clog2(NUM_REGS);
  localparam int BANK_W = BYTE_W * NUM_REGS;

  logic              rst_meta_q, rst_sync_n;
  logic [1:0]        bus_q;
  logic              scl_q, sda_q;
  logic              start_det, stop_det;
  logic              wr_en;
  logic [REG_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [BANK_W-1:0] cfg_flat;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tw_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_q)
  );

  assign scl_q = bus_q[1];
  assign sda_q = bus_q[0];

  tw_frame #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .DEFAULTS(DEFAULTS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (cfg_flat)
  );

  assign freq_sel_o  = cfg_flat[FSEL_W-1:0];
  assign spread_en_o = cfg_flat[3];
  assign tristate_o  = cfg_flat[4];
  assign out_dis_o   = cfg_flat[BANK_W-1:BYTE_W];
endmodule

// File: rtl/cfg_twowire_checker.sv
module cfg_twowire_checker #(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_q,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [REG_W-1:0]      wr_idx,
  input logic [8*NUM_REGS-1:0] cfg_flat
);
  AST_ACK_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_q); // R4

  AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_q); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o); // R8

  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o); // R10

  AST_WRITE_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe_o); // R6

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS)); // R9

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat)); // R5
endmodule

bind cfg_twowire_slave cfg_twowire_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_q     (scl_q),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .cfg_flat  (cfg_flat)
);

// File: tb/tb_cfg_twowire_slave.sv
module tb_cfg_twowire_slave;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [2:0]  freq_sel;
  logic        spread_en;
  logic        tristate;
  logic [15:0] out_dis;

  int n_chk = 0;
  int n_bad = 0;
  bit pulled_data = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_twowire_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .freq_sel_o  (freq_sel),
    .spread_en_o (spread_en),
    .tristate_o  (tristate),
    .out_dis_o   (out_dis)
  );

  // {addr, cmd, count, d2, d1, d0, expect_ack, expected {r2,r1,r0}}
  localparam logic [72:0] VEC [4] = '{
    {8'hD2, 8'h00, 8'h03, 8'h56, 8'h34, 8'h12, 1'b1, 24'h563412},
    {8'hD3, 8'h00, 8'h03, 8'hCC, 8'hBB, 8'hAA, 1'b0, 24'h563412},
    {8'hA4, 8'h00, 8'h03, 8'h11, 8'h22, 8'h33, 1'b0, 24'h563412},
    {8'hD2, 8'hFF, 8'h00, 8'h0F, 8'hF0, 8'h07, 1'b1, 24'h0FF007}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_half();
    scl_m = 1'b1; wait_half();
    sda_m = 1'b0; wait_half();
    scl_m = 1'b0; wait_half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_half();
    scl_m = 1'b1; wait_half();
    sda_m = 1'b1; wait_half();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_half();
      scl_m = 1'b1; wait_half();
      if (sda_oe) pulled_data = 1'b1;
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_half();
    scl_m = 1'b1; repeat (HALF/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                            input logic [63:0] data, input int nb, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte(a, ak); acks += int'(ak);
    send_byte(c, ak); acks += int'(ak);
    send_byte(n, ak); acks += int'(ak);
    for (int i = 0; i < nb; i++) begin
      send_byte(data[8*i +: 8], ak); acks += int'(ak);
    end
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] port_view();
    return {8'h00, out_dis, 3'b000, tristate, spread_en, freq_sel};
  endfunction

  function automatic logic [31:0] exp_view(input logic [23:0] r);
    return {8'h00, r[23:8], 3'b000, r[4:0]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int acks;
    bit ak;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: reset defaults
    check("R7 reset bank", port_view(), exp_view(24'h00000B));
    check("R7 reset oe", 32'(sda_oe), 32'd0);

    // Table of frames: R2, R3, R5, R6
    for (int v = 0; v < 4; v++) begin
      pulled_data = 1'b0;
      send_frame(VEC[v][72:65], VEC[v][64:57], VEC[v][56:49],
                 {40'd0, VEC[v][48:25]}, 3, acks);
      check(VEC[v][24] ? "R2 R5 acks on matched frame" : "R3 no ack on foreign frame",
            32'(acks), VEC[v][24] ? 32'd6 : 32'd0);
      check("R6 bank after frame", port_view(), exp_view(VEC[v][23:0]));
      check("R4 no pull during data bits", 32'(pulled_data), 32'd0);
    end

    // R9: overrun past last register
    send_frame(8'hD2, 8'h10, 8'h05, {24'd0, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01}, 5, acks);
    check("R9 overrun bytes acked", 32'(acks), 32'd8);
    check("R9 overrun discarded", port_view(), exp_view(24'h030201));

    // R6: partial frame touches register 0 only
    send_frame(8'hD2, 8'h00, 8'h01, {56'd0, 8'h1C}, 1, acks);
    check("R6 partial frame", port_view(), exp_view(24'h03021C));

    // R10: repeated start after the command byte
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h00, ak);
    send_frame(8'hD2, 8'h00, 8'h01, {56'd0, 8'hAA}, 1, acks);
    check("R10 restart acks", 32'(acks), 32'd4);
    check("R10 restart bank", port_view(), exp_view(24'h0302AA));

    // R8/R1: byte clocked after stop without start
    send_byte(8'hD2, ak);
    check("R8 no ack after stop", 32'(ak), 32'd0);
    send_byte(8'h77, ak);
    repeat (4) @(negedge clk);
    check("R8 no write after stop", port_view(), exp_view(24'h0302AA));

    // R1: a fresh start is recognised after stray clocking
    send_frame(8'hD2, 8'h00, 8'h02, {48'd0, 8'h80, 8'h07}, 2, acks);
    check("R1 start recognised", 32'(acks), 32'd5);
    check("R1 bank after start", port_view(), exp_view(24'h038007));

    // R7: reset restores defaults
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 defaults after reset", port_view(), exp_view(24'h00000B));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule